// File: doc/BRIEF.md
# Acknowledge-Free Serial Register Programming Slave

This block lets an external host program and inspect an on-chip register file at run time over three wires: a serial data-in pin, an active-low strobe pin that serves as the shift clock, and an active-low return pin that carries read data back to the host. The host is always the master and this block is always the slave. Frames are delimited the way a two-wire bus delimits them. A start is a falling data line while the shift clock is asserted. A stop is a rising data line while the shift clock is asserted. Data may only change while the shift clock is deasserted. No acknowledge slot follows any byte.

Both pins are brought into the system clock domain through two-flop synchronisers. Bits are taken MSB first on each assertion of the shift clock. A frame has three bytes: a register address, a command, and a data byte. A write command stores the data byte into the register file through a one-cycle write strobe. A read command returns the addressed register on the return pin during the third byte. The host still clocks eight bits in during that byte, and the slave ignores them.

Top module: `serprog_slave`

## Requirements
- R1: After reset, `reg_we` is 0 and `ret_n` is 1 (released).
- R2: A frame opens only on a start condition, which is `sdi` falling while `stb_n` is low. Each later falling edge of `stb_n` samples `sdi` as the next bit, MSB first.
- R3: In a frame, bits 1-8 form the address and bits 9-16 form the command. When the command is 0x01 (write), bits 17-24 form the data. After the 24th bit, `reg_waddr` equals the address and `reg_wdata` equals the data while `reg_we` is high.
- R4: `reg_we` is high for exactly one system-clock cycle per completed write frame, and never otherwise.
- R5: When the command is 0x02 (read), the register at the frame address appears on `ret_n` MSB first, inverted (pin low means 1). Bit 7-k is presented from after the (16+k)th sampling edge until the (17+k)th. At all other times `ret_n` is 1.
- R6: A start condition inside a frame discards the partial frame and begins a new one at bit 1.
- R7: A stop condition before the 24th bit aborts the frame with no write. A stop at any time also ends a read and releases `ret_n`.
- R8: A command other than 0x01 or 0x02 causes no write and leaves `ret_n` at 1 for the whole frame.
- R9: Shift-clock edges after the 24th bit and before the next start are ignored.
- R10: Shift-clock edges while no frame is open, after reset or after a stop, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sdi | input | 1 | Serial data-in pin, asynchronous |
| stb_n | input | 1 | Active-low shift-clock strobe pin, asynchronous |
| ret_n | output | 1 | Active-low serial return pin for read data |
| reg_waddr | output | 8 | Register-file write address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write enable, one-cycle pulse |
| reg_raddr | output | 8 | Register-file read address |
| reg_rdata | input | 8 | Register-file read data, combinational from `reg_raddr` |

## Verification
A pin change passes two synchroniser flops and one detection register. Its effect therefore shows on the third rising clock edge after the pin moves: `reg_we` rises three cycles after the 24th strobe assertion, and `ret_n` changes three cycles after each sampling edge. The bench holds every pin phase for at least four cycles and samples the outputs on the falling clock edge, so each result has settled before it is read. A monitor pops the expected write from a queue whenever `reg_we` is seen high. The bench reads `ret_n` after a full strobe-released phase, just before the next sampling edge.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_BYTES = 3;
  localparam int unsigned FRAME_BITS = BYTE_W * FRAME_BYTES;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CMD_WRITE = byte_t'(8'h01);
  localparam byte_t CMD_READ  = byte_t'(8'h02);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } state_t;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serprog_cond.sv
module serprog_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic din_s,
  input  logic stb_n_s,
  output logic rise,
  output logic start,
  output logic stop
);
  logic din_prev;
  logic stb_n_prev;
  logic sck_now;
  logic sck_was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_prev   <= 1'b1;
      stb_n_prev <= 1'b1;
    end else begin
      din_prev   <= din_s;
      stb_n_prev <= stb_n_s;
    end
  end

  assign sck_now = ~stb_n_s;
  assign sck_was = ~stb_n_prev;

  assign rise  = sck_now & ~sck_was;
  assign start = sck_now & sck_was & din_prev & ~din_s;
  assign stop  = sck_now & sck_was & ~din_prev & din_s;
endmodule

// File: rtl/serprog_engine.sv
module serprog_engine
  import serprog_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise,
  input  logic  start,
  input  logic  stop,
  input  logic  din,
  input  byte_t rdata,
  output byte_t addr,
  output byte_t wdata,
  output logic  we,
  output logic  ret_n
);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_BITS - 1);

  state_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  byte_t            sh_q, sh_d;
  byte_t            addr_q, addr_d;
  byte_t            cmd_q, cmd_d;
  byte_t            wdata_q, wdata_d;
  byte_t            out_q, out_d;
  logic             rd_q, rd_d;
  logic             we_q, we_d;
  byte_t            nb;

  assign nb = {sh_q[BYTE_W-2:0], din};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    wdata_d = wdata_q;
    out_d   = out_q;
    rd_d    = rd_q;
    we_d    = 1'b0;
    if (start) begin
      st_d  = ST_SHIFT;
      cnt_d = '0;
      rd_d  = 1'b0;
    end else if (stop) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      rd_d  = 1'b0;
    end else if (rise && st_q == ST_SHIFT) begin
      sh_d  = nb;
      cnt_d = cnt_q + 1'b1;
      if (rd_q) out_d = {out_q[BYTE_W-2:0], 1'b0};
      if (cnt_q == ADDR_END) addr_d = nb;
      if (cnt_q == CMD_END) begin
        cmd_d = nb;
        if (nb == CMD_READ) begin
          out_d = rdata;
          rd_d  = 1'b1;
        end
      end
      if (cnt_q == LAST) begin
        st_d = ST_DONE;
        rd_d = 1'b0;
        if (cmd_q == CMD_WRITE) begin
          we_d    = 1'b1;
          wdata_d = nb;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      wdata_q <= '0;
      out_q   <= '0;
      rd_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      wdata_q <= wdata_d;
      out_q   <= out_d;
      rd_q    <= rd_d;
      we_q    <= we_d;
    end
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign we    = we_q;
  assign ret_n = ~(rd_q & out_q[BYTE_W-1]);
endmodule

// File: rtl/serprog_slave.sv
module serprog_slave
  import serprog_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              stb_n,
  output logic              ret_n,
  output logic [BYTE_W-1:0] reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_raddr,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic [1:0] pins_s;
  logic       rise, start, stop;
  byte_t      addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  serprog_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .d    ({sdi, stb_n}),
    .q    (pins_s)
  );

  serprog_cond u_cond (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .din_s  (pins_s[1]),
    .stb_n_s(pins_s[0]),
    .rise   (rise),
    .start  (start),
    .stop   (stop)
  );

  serprog_engine u_eng (
    .clk  (clk),
    .rst_n(rst_s_n),
    .rise (rise),
    .start(start),
    .stop (stop),
    .din  (pins_s[1]),
    .rdata(reg_rdata),
    .addr (addr),
    .wdata(reg_wdata),
    .we   (reg_we),
    .ret_n(ret_n)
  );

  assign reg_waddr = addr;
  assign reg_raddr = addr;
endmodule

// File: rtl/serprog_checker.sv
module serprog_checker
  import serprog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             start,
  input logic             stop,
  input state_t           st,
  input logic [CNT_W-1:0] cnt,
  input logic             reg_we,
  input logic             ret_n
);
  // R4: write strobe lasts a single cycle
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3: write strobe only once the full frame has been counted
  assert_we_full_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (cnt == CNT_W'(FRAME_BITS) && st == ST_DONE));

  // R5 / R8: return pin released whenever no frame is shifting
  assert_ret_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_SHIFT) |-> ret_n);

  // R7: a stop closes the frame without a write
  assert_stop_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == ST_IDLE && !reg_we && ret_n));

  // R6: a start restarts the bit count
  assert_start_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == ST_SHIFT && cnt == '0));

  // R10: edges while idle are not counted
  assert_idle_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rise && !start) |=> (cnt == '0 && !reg_we));

  // R9: the count never runs past the frame length
  assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
endmodule

bind serprog_slave serprog_checker u_chk (
  .clk   (clk),
  .rst_n (rst_s_n),
  .rise  (rise),
  .start (start),
  .stop  (stop),
  .st    (u_eng.st_q),
  .cnt   (u_eng.cnt_q),
  .reg_we(reg_we),
  .ret_n (ret_n)
);

// File: tb/serprog_slave_tb.sv
module serprog_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdi = 1'b1;
  logic       stb_n = 1'b1;
  logic       ret_n;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;
  logic       reg_we;

  logic [7:0] mem [256];
  logic [15:0] exp_q [$];
  int total = 0;
  int bad = 0;
  int n_wr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serprog_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .stb_n(stb_n), .ret_n(ret_n),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  always_comb reg_rdata = mem[reg_raddr];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h96;
  end

  function automatic void check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // monitor: pop expected writes as the strobe appears (R3, R4)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      n_wr++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected write", {reg_waddr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({reg_waddr, reg_wdata} == e, "R3 write addr/data",
              {reg_waddr, reg_wdata}, e);
      end
      mem[reg_waddr] = reg_wdata;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    sdi = 1'b1; tick(4);
    stb_n = 1'b0; tick(4);
    sdi = 1'b0; tick(4);
    stb_n = 1'b1; tick(4);
  endtask

  task automatic do_stop();
    sdi = 1'b0; tick(4);
    stb_n = 1'b0; tick(4);
    sdi = 1'b1; tick(4);
    stb_n = 1'b1; tick(4);
  endtask

  task automatic send_bit(bit b);
    sdi = b; tick(4);
    stb_n = 1'b0; tick(4);
    stb_n = 1'b1; tick(2);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // third byte of a read: checks ret_n before each sampling edge (R5)
  task automatic read_byte(logic [7:0] exp, string tag);
    for (int i = 7; i >= 0; i--) begin
      sdi = 1'b0; tick(4);
      @(negedge clk);
      check(ret_n == ~exp[i], tag, ret_n, ~exp[i]);
      #1 stb_n = 1'b0; tick(4);
      stb_n = 1'b1; tick(2);
    end
    tick(4);
    @(negedge clk);
    check(ret_n == 1'b1, "R5 released after read", ret_n, 1);
    #1;
  endtask

  task automatic write_frame(logic [7:0] a, logic [7:0] d);
    exp_q.push_back({a, d});
    do_start();
    send_byte(a); send_byte(8'h01); send_byte(d);
    do_stop();
  endtask

  task automatic read_frame(logic [7:0] a, logic [7:0] exp, string tag);
    do_start();
    send_byte(a); send_byte(8'h02);
    read_byte(exp, tag);
    do_stop();
  endtask

  initial begin
    int w0;
    tick(5);
    @(negedge clk);
    check(reg_we == 1'b0, "R1 reg_we at reset", reg_we, 0);
    check(ret_n == 1'b1, "R1 ret_n at reset", ret_n, 1);
    #1 rst_n = 1'b1;
    tick(6);
    @(negedge clk);
    check(ret_n == 1'b1 && reg_we == 1'b0, "R1 after release", {ret_n, reg_we}, 2);
    #1;

    // R2 R3 R4: plain writes, one strobe each
    w0 = n_wr;
    write_frame(8'hA0, 8'h5A);
    write_frame(8'h3C, 8'hC3);
    tick(4);
    check(n_wr - w0 == 2, "R4 one strobe per frame", n_wr - w0, 2);

    // R5: reads of written and untouched registers
    read_frame(8'hA0, 8'h5A, "R5 read A0");
    read_frame(8'h3C, 8'hC3, "R5 read 3C");
    read_frame(8'h11, 8'h11 ^ 8'h96, "R5 read 11");

    // R10: clocks with no start are ignored
    w0 = n_wr;
    send_byte(8'h55); send_byte(8'h01); send_byte(8'hEE);
    tick(4);
    check(n_wr == w0, "R10 no write without start", n_wr - w0, 0);
    read_frame(8'h55, 8'h55 ^ 8'h96, "R10 reg 55 unchanged");

    // R7: stop after 16 bits aborts
    w0 = n_wr;
    do_start();
    send_byte(8'h22); send_byte(8'h01);
    do_stop();
    tick(4);
    check(n_wr == w0, "R7 short frame no write", n_wr - w0, 0);
    read_frame(8'h22, 8'h22 ^ 8'h96, "R7 reg 22 unchanged");

    // R7: stop in the middle of a read releases ret_n
    do_start();
    send_byte(8'hA0); send_byte(8'h02);
    do_stop();
    @(negedge clk);
    check(ret_n == 1'b1, "R7 stop releases ret_n", ret_n, 1);
    #1;

    // R6: restart mid-frame
    w0 = n_wr;
    do_start();
    send_byte(8'hFF); send_bit(1'b1); send_bit(1'b0);
    write_frame(8'h44, 8'h77);
    tick(4);
    check(n_wr - w0 == 1, "R6 single write after restart", n_wr - w0, 1);
    read_frame(8'h44, 8'h77, "R6 read 44");

    // R8: unknown command
    w0 = n_wr;
    do_start();
    send_byte(8'h66); send_byte(8'h07);
    read_byte(8'h00, "R8 ret_n stays released");
    do_stop();
    tick(4);
    check(n_wr == w0, "R8 no write on unknown cmd", n_wr - w0, 0);

    // R9: extra bits after a complete frame
    w0 = n_wr;
    exp_q.push_back({8'h70, 8'h0F});
    do_start();
    send_byte(8'h70); send_byte(8'h01); send_byte(8'h0F);
    send_byte(8'hAA);
    do_stop();
    tick(4);
    check(n_wr - w0 == 1, "R9 trailing bits ignored", n_wr - w0, 1);
    read_frame(8'h70, 8'h0F, "R9 read 70");

    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule